// File: doc/BRIEF.md
# Clock Time-Set Controller With Auto-Repeat

This block keeps the time of day as six BCD digits in 24-hour form and lets a user set it with three push buttons: one for seconds, one for minutes and one for hours. The running time advances once per second from a prescaler that divides the system clock. Each raw, active-low button is brought into the clock domain by two flip-flops. It is then debounced, and every accepted press steps its field by one. A button kept down past a hold threshold starts a fast auto-repeat that runs until release.

A field stepped from a button wraps inside its own range and never carries into the next field. Stepping the seconds restarts the one-second interval. When a button step and an automatic advance land on the same field in the same cycle, exactly one increment is applied and no carry leaves that field. All timing constants are parameters. The defaults assume a 50 MHz clock, a 10 ms debounce window, a 2 s hold threshold and 8 repeats per second.

Top module: `clkset_top`

## Requirements
- R1: While rst_ni is low, all six digits read zero, and the prescaler, debounce and hold timers restart from zero.
- R2: Every CYC_PER_SEC cycles the seconds advance by one. Seconds and minutes wrap from 59 to 00 and carry into the next field. Hours wrap from 23 to 00, so 23:59:59 is followed by 00:00:00.
- R3: A button level must be stable for DEB_CYC consecutive cycles after synchronization before it is accepted. A low pulse shorter than that changes nothing.
- R4: Each accepted press advances its field by exactly one. Bit 0 of btn_ni steps seconds, bit 1 steps minutes and bit 2 steps hours.
- R5: If a press lasts D accepted cycles, its field advances 1 step when D <= HOLD_CYC, and otherwise 2 + (D-1-HOLD_CYC)/RPT_CYC steps (integer division). The first repeat comes HOLD_CYC cycles after acceptance and the following ones every RPT_CYC cycles.
- R6: A button step wraps its field only: minutes 59 becomes 00 and hours 23 becomes 00, with the neighbouring fields unchanged.
- R7: A seconds button step clears the prescaler, so the next automatic advance comes CYC_PER_SEC cycles after that step.
- R8: If a button step and an automatic advance reach the same field in one cycle, that field advances by one and emits no carry.
- R9: A button changes only its own field.
- R10: time_bcd_o holds {hours tens, hours units, minutes tens, minutes units, seconds tens, seconds units}, 4 bits each, with hours tens in bits 23:20 and seconds units in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| btn_ni | input | 3 | Raw active-low buttons: [0] seconds, [1] minutes, [2] hours |
| time_bcd_o | output | 24 | Current time as six BCD digits (layout in R10) |

## Verification
The hardest case to reach from the ports is a button step that falls in the exact cycle of an automatic advance. This matters for the seconds field against the prescaler tick, and for the minutes field against a carry out of seconds. The bench first measures the fixed latency from a raw button edge to the step. It then takes the cycle of the last seconds step, which cleared the prescaler, as a timing anchor. From these two values it schedules the next press so that its step lands on the predicted tick edge.

// File: rtl/clkset_pkg.sv
package clkset_pkg;
  typedef logic [3:0] bcd_t;
  typedef struct packed {
    bcd_t tens;
    bcd_t ones;
  } bcd2_t;
  localparam int unsigned NFIELD = 3;
endpackage

// File: rtl/clkset_prescale.sv
module clkset_prescale #(
  parameter int unsigned CYC_PER_SEC = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(CYC_PER_SEC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R7: a cleared prescaler cannot tick in the following cycle
  a_r7_clr_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !tick_o);
endmodule

// File: rtl/clkset_btn.sv
module clkset_btn #(
  parameter int unsigned DEB_CYC  = 500_000,
  parameter int unsigned HOLD_CYC = 100_000_000,
  parameter int unsigned RPT_CYC  = 6_250_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_ni,
  output logic step_o
);
  localparam int unsigned DW = $clog2(DEB_CYC + 1);
  localparam int unsigned HW = $clog2(HOLD_CYC + 1);
  localparam int unsigned RW = $clog2(RPT_CYC + 1);
  localparam logic [DW-1:0] DEB_LAST = DW'(DEB_CYC - 1);
  localparam logic [HW-1:0] HOLD_MAX = HW'(HOLD_CYC);
  localparam logic [RW-1:0] RPT_LAST = RW'(RPT_CYC - 1);

  logic [1:0]    sync_q;
  logic [DW-1:0] deb_cnt_q;
  logic          db_q, db_prev_q;
  logic [HW-1:0] hold_cnt_q;
  logic [RW-1:0] rpt_cnt_q;
  logic          rep_mode, press;

  // sync_q holds "pressed" (inverted raw level)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], ~btn_ni};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deb_cnt_q <= '0;
      db_q      <= 1'b0;
    end else if (sync_q[1] == db_q) begin
      deb_cnt_q <= '0;
    end else if (deb_cnt_q == DEB_LAST) begin
      deb_cnt_q <= '0;
      db_q      <= sync_q[1];
    end else begin
      deb_cnt_q <= deb_cnt_q + 1'b1;
    end
  end

  assign rep_mode = (hold_cnt_q == HOLD_MAX);
  assign press    = db_q & ~db_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      db_prev_q  <= 1'b0;
      hold_cnt_q <= '0;
      rpt_cnt_q  <= '0;
    end else begin
      db_prev_q <= db_q;
      if (!db_q)          hold_cnt_q <= '0;
      else if (!rep_mode) hold_cnt_q <= hold_cnt_q + 1'b1;
      if (!rep_mode || !db_q)       rpt_cnt_q <= '0;
      else if (rpt_cnt_q == RPT_LAST) rpt_cnt_q <= '0;
      else                          rpt_cnt_q <= rpt_cnt_q + 1'b1;
    end
  end

  assign step_o = press | (db_q & rep_mode & (rpt_cnt_q == '0));

  // R4: steps only while the debounced button is down
  a_r4_step_needs_press: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> db_q);
  // R3: the accepted level only ever moves to the synchronized level
  a_r3_db_follows_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(db_q) |-> (db_q == $past(sync_q[1])));
  // R5: auto-repeat never overlaps the initial press step
  a_r5_rep_after_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press |-> !rep_mode);
endmodule

// File: rtl/clkset_field.sv
module clkset_field
  import clkset_pkg::*;
#(
  parameter bcd_t WRAP_TENS = 4'd5,
  parameter bcd_t WRAP_ONES = 4'd9
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  step_i,
  output bcd2_t val_o,
  output logic  carry_o
);
  bcd2_t val_q, val_nxt;
  logic  at_max;

  assign at_max  = (val_q.tens == WRAP_TENS) && (val_q.ones == WRAP_ONES);
  // a button step consumes any concurrent carry and never propagates one
  assign carry_o = tick_i & ~step_i & at_max;

  always_comb begin
    val_nxt = val_q;
    if (at_max) begin
      val_nxt = '0;
    end else if (val_q.ones == 4'd9) begin
      val_nxt.ones = 4'd0;
      val_nxt.tens = val_q.tens + 4'd1;
    end else begin
      val_nxt.ones = val_q.ones + 4'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               val_q <= '0;
    else if (tick_i || step_i) val_q <= val_nxt;
  end

  assign val_o = val_q;

  // R2/R6: digits stay inside the field's range
  a_r2_digit_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (val_q.ones <= 4'd9) && (val_q.tens <= WRAP_TENS) &&
    !((val_q.tens == WRAP_TENS) && (val_q.ones > WRAP_ONES)));
  // R2: an emitted carry leaves the field at zero
  a_r2_carry_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |=> (val_q == '0));
  // R8: a field without a step or tick keeps its value
  a_r8_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !step_i) |=> $stable(val_q));
endmodule

// File: rtl/clkset_top.sv
module clkset_top
  import clkset_pkg::*;
#(
  parameter int unsigned CYC_PER_SEC = 50_000_000,
  parameter int unsigned DEB_CYC     = 500_000,
  parameter int unsigned HOLD_CYC    = 100_000_000,
  parameter int unsigned RPT_CYC     = 6_250_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  btn_ni,
  output logic [23:0] time_bcd_o
);
  logic [NFIELD-1:0] step, carry, tick_in;
  bcd2_t             val [NFIELD];
  logic              sec_tick;

  clkset_prescale #(.CYC_PER_SEC(CYC_PER_SEC)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (step[0]),
    .tick_o (sec_tick)
  );

  // field 0 = seconds, 1 = minutes, 2 = hours
  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    clkset_btn #(
      .DEB_CYC  (DEB_CYC),
      .HOLD_CYC (HOLD_CYC),
      .RPT_CYC  (RPT_CYC)
    ) u_btn (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .btn_ni (btn_ni[i]),
      .step_o (step[i])
    );

    if (i == 0) begin : g_src
      assign tick_in[i] = sec_tick;
    end else begin : g_src
      assign tick_in[i] = carry[i-1];
    end

    clkset_field #(
      .WRAP_TENS ((i == NFIELD-1) ? 4'd2 : 4'd5),
      .WRAP_ONES ((i == NFIELD-1) ? 4'd3 : 4'd9)
    ) u_field (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_in[i]),
      .step_i  (step[i]),
      .val_o   (val[i]),
      .carry_o (carry[i])
    );

    assign time_bcd_o[8*i +: 8] = val[i];
  end

  // R9: without tick or step the whole time is frozen
  a_r9_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_tick && (step == '0)) |=> $stable(time_bcd_o));
  // R2: hours never leave 00..23
  a_r2_hours_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (time_bcd_o[23:20] < 4'd2) || (time_bcd_o[19:16] <= 4'd3));
  // R6: the hours carry is never produced into nothing else
  a_r6_no_top_carry_on_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step[1] |-> !carry[1]);
endmodule

// File: tb/clkset_top_tb.sv
module clkset_top_tb;
  localparam int CPS  = 1000;
  localparam int DEB  = 4;
  localparam int HOLD = 40;
  localparam int RPT  = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  btn_n = 3'b111;
  logic [23:0] tm;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int lat = 0, last_chg = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clkset_top #(.CYC_PER_SEC(CPS), .DEB_CYC(DEB), .HOLD_CYC(HOLD), .RPT_CYC(RPT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .btn_ni(btn_n), .time_bcd_o(tm));

  function automatic int fv(int f);
    return tm[8*f+4 +: 4] * 10 + tm[8*f +: 4];
  endfunction

  function automatic int nsteps(int d);
    return (d <= HOLD) ? 1 : 2 + (d - 1 - HOLD) / RPT;
  endfunction

  function automatic int dur_for(int n);
    return (n <= 1) ? 10 : HOLD + 1 + (n - 2) * RPT;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset digits", int'(tm), 0);
    rst_n = 1'b1;
  endtask

  // button idx low for p sampled edges; tracks last seconds change
  task automatic hold(int idx, int p);
    int prev = fv(0);
    @(negedge clk); btn_n[idx] = 1'b0;
    for (int j = 1; j <= p + DEB + 20; j++) begin
      @(negedge clk);
      if (j == p) btn_n[idx] = 1'b1;
      if (fv(0) != prev) begin prev = fv(0); last_chg = cyc; end
    end
  endtask

  initial begin
    int k, m, t;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 reset digits", int'(tm), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // phase A: minutes and hours via buttons
    hold(1, DEB - 1);
    chk("R3 glitch ignored", fv(1), 0);
    for (int i = 1; i <= 3; i++) begin
      hold(1, 10);
      chk("R4 single press", fv(1), i);
    end
    hold(1, HOLD);
    chk("R5 hold at threshold single", fv(1), 3 + nsteps(HOLD));
    chk("R9 hours untouched", fv(2), 0);
    hold(1, dur_for(59 - fv(1)));
    chk("R5 minutes to 59", fv(1), 59);
    hold(1, 10);
    chk("R6 minutes wrap", fv(1), 0);
    chk("R6 hours no carry", fv(2), 0);
    hold(2, dur_for(23));
    chk("R5 hours to 23", fv(2), 23);
    hold(2, 10);
    chk("R6 hours wrap", fv(2), 0);
    chk("R9 minutes untouched", fv(1), 0);

    // phase B: coincidence of button step and tick
    do_reset();
    @(negedge clk);
    k = cyc; m = -1; btn_n[0] = 1'b0;
    for (int j = 1; j <= 40; j++) begin
      @(negedge clk);
      if (j == 10) btn_n[0] = 1'b1;
      if (m < 0 && fv(0) == 1) m = cyc;
    end
    lat = m - k;
    chk("R4 seconds press", fv(0), 1);
    wait_cyc(m + CPS - 10);
    chk("R7 no tick before full second", fv(0), 1);
    wait_cyc(m + CPS + 5);
    chk("R7 tick one second after step", fv(0), 2);
    t = m + 2 * CPS;
    wait_cyc(t - lat);
    btn_n[0] = 1'b0;
    repeat (10) @(negedge clk);
    btn_n[0] = 1'b1;
    wait_cyc(t + 5);
    chk("R8 seconds step on tick edge", fv(0), 3);
    wait_cyc(t + CPS - 5);
    chk("R8 R7 no extra advance", fv(0), 3);
    wait_cyc(t + CPS + 5);
    chk("R7 next tick after clear", fv(0), 4);
    hold(0, dur_for(55));
    chk("R5 seconds to 59", fv(0), 59);
    t = last_chg + CPS;
    wait_cyc(t - lat);
    btn_n[1] = 1'b0;
    repeat (10) @(negedge clk);
    btn_n[1] = 1'b1;
    wait_cyc(t + 5);
    chk("R8 seconds wrapped", fv(0), 0);
    chk("R8 minutes single advance", fv(1), 1);

    // phase C: full day rollover
    do_reset();
    hold(0, dur_for(58));
    m = last_chg;
    chk("R5 seconds to 58", fv(0), 58);
    hold(2, dur_for(23));
    hold(1, dur_for(59));
    wait_cyc(m + CPS + 5);
    chk("R10 R2 23:59:59 layout", int'(tm), 24'h235959);
    wait_cyc(m + 2 * CPS + 5);
    chk("R2 day rollover", int'(tm), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule